// File: doc/BRIEF.md
# Saturating Integer Arithmetic Unit

This block performs one 32-bit integer operation per cycle and clamps the result when it falls outside the representable range. A 4-bit opcode picks one of ten operations. The first group is signed addition and subtraction, including a variant that wraps and only reports overflow. The second group is saturating doubling and unsigned addition and subtraction. The third group clamps a signed or unsigned value to a programmable bit width, either as a full word or as two independent halfwords. The result is combinational from the operands. The opcode, operands and width are ignored unless the `valid` strobe is high.

Every clamping event, and every overflow of the wrap-only add, sets one shared sticky flag. The flag is held in a two-state machine. `FLAG_CLEAN` moves to `FLAG_STUCK` on a qualified saturation event (transition *set*). `FLAG_STUCK` returns to `FLAG_CLEAN` only on the `clr` strobe (transition *clear*). In all other cases the state does not change (transition *hold*). Software-visible status is the flag alone, and it can be read at the port.

Top module: `sat_arith_unit`

## Requirements
- R1: Opcodes are 0 wrap-add-flag, 1 signed add, 2 signed subtract, 3 doubling, 4 unsigned add, 5 unsigned subtract, 6 signed word clamp, 7 unsigned word clamp, 8 signed dual-halfword clamp, 9 unsigned dual-halfword clamp. When `valid` is low, or for opcodes 10 to 15, `result` is 0 and no saturation event occurs.
- R2: Signed add overflows when both operands have the same sign and the sum's sign differs from `a`. Signed subtract overflows when the operand signs differ and the difference's sign differs from `a`. On overflow the result is 0x7FFFFFFF if `a` is non-negative, and 0x80000000 otherwise.
- R3: The wrap-add-flag opcode returns the 32-bit wrapped sum without clamping. Its signed overflow still counts as a saturation event.
- R4: Doubling of `a` returns 0x7FFFFFFF when `a` ≥ 0x40000000 (signed) and 0x80000000 when `a` ≤ 0xC0000000 (signed); both are events. Otherwise it returns 2·`a`.
- R5: Unsigned add returns 0xFFFFFFFF on a carry out. Unsigned subtract returns 0 when `a` < `b`. Both cases are events.
- R6: The signed word clamp limits `a` to the range [−2^w, 2^w − 1], where w = `width`.
- R7: The unsigned word clamp returns 0 for negative `a` and 2^w − 1 for `a` above that value.
- R8: The dual-halfword clamps treat `a[15:0]` and `a[31:16]` as sign-extended values. Each half is clamped independently, as in R6 or R7, and its low 16 bits are placed back in its own half. A clamp in either half is an event.
- R9: `sat_flag` becomes 1 in the cycle after a valid saturation event, and stays 1 until it is cleared.
- R10: `sat_flag` resets to 0. `clr` forces it to 0 on the next edge, even when a saturation event arrives in the same cycle.
- R11: A saturating operand set presented with `valid` low leaves `sat_flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid | input | 1 | Qualifies the operation |
| clr | input | 1 | Clears the sticky flag |
| op | input | 4 | Operation select (R1) |
| a | input | 32 | First operand / value to clamp |
| b | input | 32 | Second operand |
| width | input | 5 | Clamp width for opcodes 6 to 9 |
| result | output | 32 | Operation result |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The bench targets the edges where the overflow tests change: 0x7FFFFFFF+1, 0x80000000−1, 0−0x80000000 and the doubling thresholds 0x40000000 and 0xC0000000. A design that tested the wrong operand sign would clamp in the wrong direction, or would miss the subtract overflow. Width zero and width 31 probe the clamp limits; an off-by-one limit would pass one value too many. The halfword forms use one saturating half next to one clean half, so a design that shares the clamp decision across halves would corrupt the clean half. The bench also drives a clear together with an event, and an event with `valid` low; a wrong flag priority or a missing qualification leaves the flag set.

// File: rtl/sat_pkg.sv
package sat_pkg;
    typedef enum logic [3:0] {
        OP_ADD_WRAPF = 4'd0,
        OP_SADD      = 4'd1,
        OP_SSUB      = 4'd2,
        OP_SDOUBLE   = 4'd3,
        OP_UADD      = 4'd4,
        OP_USUB      = 4'd5,
        OP_SCLAMP    = 4'd6,
        OP_UCLAMP    = 4'd7,
        OP_SCLAMP_H  = 4'd8,
        OP_UCLAMP_H  = 4'd9
    } sat_op_e;

    typedef enum logic {
        FLAG_CLEAN = 1'b0,
        FLAG_STUCK = 1'b1
    } flag_state_e;
endpackage

// File: rtl/sat_addsub.sv
module sat_addsub #(
    parameter int DATA_W = 32,
    parameter bit SIGNED = 1'b1
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    input  logic              clamp,
    output logic [DATA_W-1:0] res,
    output logic              ovf
);
    localparam int MSB = DATA_W - 1;

    generate
        if (SIGNED) begin : g_signed
            logic [DATA_W-1:0] raw;
            logic [DATA_W-1:0] limit;
            always_comb begin
                raw   = sub ? (a - b) : (a + b);
                ovf   = sub ? ((a[MSB] ^ b[MSB]) & (raw[MSB] ^ a[MSB]))
                            : (~(a[MSB] ^ b[MSB]) & (raw[MSB] ^ a[MSB]));
                limit = a[MSB] ? {1'b1, {MSB{1'b0}}} : {1'b0, {MSB{1'b1}}};
                res   = (clamp && ovf) ? limit : raw;
            end
        end else begin : g_unsigned
            logic [DATA_W:0] wide;
            always_comb begin
                wide = sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
                ovf  = wide[DATA_W];
                if (clamp && ovf) res = sub ? '0 : '1;
                else              res = wide[DATA_W-1:0];
            end
        end
    endgenerate
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
    parameter int DATA_W = 32,
    parameter int SHW    = 5
) (
    input  logic [DATA_W-1:0] val,
    input  logic [SHW-1:0]    width,
    input  logic              is_signed,
    output logic [DATA_W-1:0] res,
    output logic              sat
);
    localparam int EXT_W = DATA_W + 1;

    logic signed [EXT_W-1:0] v_ext;
    logic signed [EXT_W-1:0] lim;
    logic signed [EXT_W-1:0] hi;
    logic signed [EXT_W-1:0] lo;
    logic signed [EXT_W-1:0] pick;

    always_comb begin
        v_ext = $signed({val[DATA_W-1], val});
        lim   = $signed({{DATA_W{1'b0}}, 1'b1} << width);
        hi    = lim - 1;
        lo    = -lim;
        pick  = v_ext;
        sat   = 1'b0;
        if (is_signed) begin
            if (v_ext > hi) begin
                pick = hi;
                sat  = 1'b1;
            end else if (v_ext < lo) begin
                pick = lo;
                sat  = 1'b1;
            end
        end else begin
            if (v_ext < 0) begin
                pick = '0;
                sat  = 1'b1;
            end else if (v_ext > hi) begin
                pick = hi;
                sat  = 1'b1;
            end
        end
        res = pick[DATA_W-1:0];
    end
endmodule

// File: rtl/sat_flag_fsm.sv
module sat_flag_fsm
    import sat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic set_req,
    output logic flag
);
    flag_state_e state_q;
    flag_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAN: if (!clr && set_req) state_d = FLAG_STUCK;
            FLAG_STUCK: if (clr)             state_d = FLAG_CLEAN;
            default:                         state_d = FLAG_CLEAN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_CLEAN;
        else        state_q <= state_d;
    end

    always_comb begin
        flag = (state_q == FLAG_STUCK);
    end
endmodule

// File: rtl/sat_arith_unit.sv
module sat_arith_unit
    import sat_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SHW    = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              clr,
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [SHW-1:0]    width,
    output logic [DATA_W-1:0] result,
    output logic              sat_flag
);
    localparam int HALF_W = DATA_W / 2;
    localparam int MSB    = DATA_W - 1;

    logic [DATA_W-1:0] s_res, u_res, w_res, dbl_res;
    logic              s_ovf, u_ovf, w_sat, dbl_sat;
    logic              s_sub, u_sub, s_clamp, clamp_signed;
    logic [DATA_W-1:0] h_res [2];
    logic              h_sat [2];
    logic [DATA_W-1:0] raw_res;
    logic              raw_sat;
    logic              sat_evt;
    sat_op_e           op_e;

    assign op_e         = sat_op_e'(op);
    assign s_sub        = (op_e == OP_SSUB);
    assign s_clamp      = (op_e != OP_ADD_WRAPF);
    assign u_sub        = (op_e == OP_USUB);
    assign clamp_signed = (op_e == OP_SCLAMP) || (op_e == OP_SCLAMP_H);

    sat_addsub #(.DATA_W(DATA_W), .SIGNED(1'b1)) i_sadd (
        .a(a), .b(b), .sub(s_sub), .clamp(s_clamp), .res(s_res), .ovf(s_ovf)
    );

    sat_addsub #(.DATA_W(DATA_W), .SIGNED(1'b0)) i_uadd (
        .a(a), .b(b), .sub(u_sub), .clamp(1'b1), .res(u_res), .ovf(u_ovf)
    );

    sat_clamp #(.DATA_W(DATA_W), .SHW(SHW)) i_wclamp (
        .val(a), .width(width), .is_signed(clamp_signed), .res(w_res), .sat(w_sat)
    );

    generate
        for (genvar g = 0; g < 2; g++) begin : g_half
            logic [HALF_W-1:0] h_in;
            assign h_in = a[g*HALF_W +: HALF_W];
            sat_clamp #(.DATA_W(DATA_W), .SHW(SHW)) i_hclamp (
                .val({{HALF_W{h_in[HALF_W-1]}}, h_in}),
                .width(width),
                .is_signed(clamp_signed),
                .res(h_res[g]),
                .sat(h_sat[g])
            );
        end
    endgenerate

    // doubling with thresholds at a quarter of the range
    always_comb begin
        dbl_sat = 1'b0;
        dbl_res = {a[MSB-1:0], 1'b0};
        if (!a[MSB] && a[MSB-1]) begin
            dbl_res = {1'b0, {MSB{1'b1}}};
            dbl_sat = 1'b1;
        end else if (a[MSB] && (!a[MSB-1] || (a[MSB-2:0] == '0))) begin
            dbl_res = {1'b1, {MSB{1'b0}}};
            dbl_sat = 1'b1;
        end
    end

    always_comb begin
        raw_res = '0;
        raw_sat = 1'b0;
        unique case (op)
            OP_ADD_WRAPF, OP_SADD, OP_SSUB: begin
                raw_res = s_res;
                raw_sat = s_ovf;
            end
            OP_SDOUBLE: begin
                raw_res = dbl_res;
                raw_sat = dbl_sat;
            end
            OP_UADD, OP_USUB: begin
                raw_res = u_res;
                raw_sat = u_ovf;
            end
            OP_SCLAMP, OP_UCLAMP: begin
                raw_res = w_res;
                raw_sat = w_sat;
            end
            OP_SCLAMP_H, OP_UCLAMP_H: begin
                raw_res = {h_res[1][HALF_W-1:0], h_res[0][HALF_W-1:0]};
                raw_sat = h_sat[0] | h_sat[1];
            end
            default: begin
                raw_res = '0;
                raw_sat = 1'b0;
            end
        endcase
    end

    assign result  = valid ? raw_res : '0;
    assign sat_evt = valid & raw_sat;

    sat_flag_fsm i_flag (
        .clk(clk), .rst_n(rst_n), .clr(clr), .set_req(sat_evt), .flag(sat_flag)
    );
endmodule

// File: rtl/sat_arith_chk.sv
module sat_arith_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid,
    input logic              clr,
    input logic [3:0]        op,
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] result,
    input logic              sat_flag,
    input logic              sat_evt
);
    // R10
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !sat_flag);

    // R9
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag && !clr) |=> sat_flag);

    // R9
    set_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_evt && !clr) |=> sat_flag);

    // R11
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sat_flag && !sat_evt) |=> !sat_flag);

    // R1
    idle_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (result == '0) && !sat_evt);

    // R5
    uadd_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op == 4'd4) |-> (result >= a));
endmodule

bind sat_arith_unit sat_arith_chk #(.DATA_W(DATA_W)) i_sat_arith_chk (
    .clk(clk), .rst_n(rst_n), .valid(valid), .clr(clr), .op(op), .a(a),
    .result(result), .sat_flag(sat_flag), .sat_evt(sat_evt)
);

// File: tb/test_sat_arith_unit.sv
module test_sat_arith_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic        clr = 1'b0;
    logic [3:0]  op = '0;
    logic [31:0] a = '0, b = '0;
    logic [4:0]  width = '0;
    logic [31:0] result;
    logic        sat_flag;

    int checks = 0;
    int errors = 0;
    bit exp_flag = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sat_arith_unit i_sat_arith_unit (
        .clk(clk), .rst_n(rst_n), .valid(valid), .clr(clr), .op(op),
        .a(a), .b(b), .width(width), .result(result), .sat_flag(sat_flag)
    );

    function automatic logic [32:0] ref_ssat(longint v, int w);
        longint hi = (longint'(1) << w) - 1;
        longint lo = -(longint'(1) << w);
        if (v > hi) return {1'b1, 32'(hi)};
        if (v < lo) return {1'b1, 32'(lo)};
        return {1'b0, 32'(v)};
    endfunction

    function automatic logic [32:0] ref_usat(longint v, int w);
        longint hi = (longint'(1) << w) - 1;
        if (v < 0)  return {1'b1, 32'd0};
        if (v > hi) return {1'b1, 32'(hi)};
        return {1'b0, 32'(v)};
    endfunction

    // returns {event, result}
    function automatic logic [32:0] model(logic [3:0] o, logic [31:0] x, logic [31:0] y, int w);
        longint sx = longint'($signed(x));
        longint sy = longint'($signed(y));
        longint ux = longint'(x);
        longint uy = longint'(y);
        longint t;
        logic [32:0] lo_h, hi_h;
        case (o)
            4'd0: begin
                t = sx + sy;
                return {(t > 64'sd2147483647) || (t < -64'sd2147483648), 32'(t)};
            end
            4'd1, 4'd2: begin
                t = (o == 4'd1) ? sx + sy : sx - sy;
                if (t > 64'sd2147483647 || t < -64'sd2147483648)
                    return {1'b1, (sx >= 0) ? 32'h7FFF_FFFF : 32'h8000_0000};
                return {1'b0, 32'(t)};
            end
            4'd3: begin
                if (sx >= 64'sd1073741824)  return {1'b1, 32'h7FFF_FFFF};
                if (sx <= -64'sd1073741824) return {1'b1, 32'h8000_0000};
                return {1'b0, 32'(2 * sx)};
            end
            4'd4: begin
                t = ux + uy;
                if (t > 64'hFFFF_FFFF) return {1'b1, 32'hFFFF_FFFF};
                return {1'b0, 32'(t)};
            end
            4'd5: begin
                if (ux < uy) return {1'b1, 32'd0};
                return {1'b0, 32'(ux - uy)};
            end
            4'd6: return ref_ssat(sx, w);
            4'd7: return ref_usat(sx, w);
            4'd8, 4'd9: begin
                if (o == 4'd8) begin
                    lo_h = ref_ssat(longint'($signed(x[15:0])), w);
                    hi_h = ref_ssat(longint'($signed(x[31:16])), w);
                end else begin
                    lo_h = ref_usat(longint'($signed(x[15:0])), w);
                    hi_h = ref_usat(longint'($signed(x[31:16])), w);
                end
                return {lo_h[32] | hi_h[32], hi_h[15:0], lo_h[15:0]};
            end
            default: return 33'd0;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run(string req, logic [3:0] o, logic [31:0] x, logic [31:0] y,
                       int w, bit v, bit c);
        logic [32:0] m;
        @(negedge clk);
        op = o; a = x; b = y; width = 5'(w); valid = v; clr = c;
        #1;
        m = model(o, x, y, w);
        check(req, result, v ? m[31:0] : 32'd0);
        @(posedge clk);
        if (c) exp_flag = 1'b0;
        else if (v && m[32]) exp_flag = 1'b1;
        #1;
        check({req, " flag"}, {31'd0, sat_flag}, {31'd0, exp_flag});
        valid = 1'b0; clr = 1'b0;
    endtask

    task automatic do_clear();
        run("R10", 4'd15, 32'd0, 32'd0, 0, 1'b0, 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset", {31'd0, sat_flag}, 32'd0);
        rst_n = 1'b1;

        // R1: idle and undefined opcodes
        run("R1", 4'd1, 32'h7FFF_FFFF, 32'd1, 0, 1'b0, 1'b0);
        run("R11", 4'd4, 32'hFFFF_FFFF, 32'd5, 0, 1'b0, 1'b0);
        run("R1", 4'd12, 32'h1234_5678, 32'h9ABC_DEF0, 3, 1'b1, 1'b0);
        // R2 corners
        run("R2", 4'd1, 32'h7FFF_FFFF, 32'd1, 0, 1'b1, 1'b0);
        run("R9", 4'd1, 32'd1, 32'd2, 0, 1'b1, 1'b0);
        do_clear();
        run("R2", 4'd1, 32'h8000_0000, 32'hFFFF_FFFF, 0, 1'b1, 1'b0);
        do_clear();
        run("R2", 4'd2, 32'h8000_0000, 32'd1, 0, 1'b1, 1'b0);
        run("R2", 4'd2, 32'd0, 32'h8000_0000, 0, 1'b1, 1'b0);
        // R10 clear wins over event
        run("R10", 4'd2, 32'd0, 32'h8000_0000, 0, 1'b1, 1'b1);
        // R3
        run("R3", 4'd0, 32'h7FFF_FFFF, 32'd1, 0, 1'b1, 1'b0);
        do_clear();
        run("R3", 4'd0, 32'h0000_0010, 32'hFFFF_FFF0, 0, 1'b1, 1'b0);
        // R4
        run("R4", 4'd3, 32'h3FFF_FFFF, 32'd0, 0, 1'b1, 1'b0);
        run("R4", 4'd3, 32'h4000_0000, 32'd0, 0, 1'b1, 1'b0);
        do_clear();
        run("R4", 4'd3, 32'hC000_0000, 32'd0, 0, 1'b1, 1'b0);
        do_clear();
        run("R4", 4'd3, 32'hC000_0001, 32'd0, 0, 1'b1, 1'b0);
        // R5
        run("R5", 4'd4, 32'hFFFF_FFFF, 32'd1, 0, 1'b1, 1'b0);
        do_clear();
        run("R5", 4'd5, 32'd1, 32'd2, 0, 1'b1, 1'b0);
        do_clear();
        run("R5", 4'd5, 32'd7, 32'd7, 0, 1'b1, 1'b0);
        // R6, R7
        run("R6", 4'd6, 32'd200, 32'd0, 7, 1'b1, 1'b0);
        do_clear();
        run("R6", 4'd6, 32'hFFFF_FF80, 32'd0, 7, 1'b1, 1'b0);
        run("R6", 4'd6, 32'hFFFF_FFFF, 32'd0, 0, 1'b1, 1'b0);
        run("R6", 4'd6, 32'h8000_0000, 32'd0, 31, 1'b1, 1'b0);
        run("R7", 4'd7, 32'hFFFF_FFFB, 32'd0, 8, 1'b1, 1'b0);
        do_clear();
        run("R7", 4'd7, 32'd255, 32'd0, 8, 1'b1, 1'b0);
        run("R7", 4'd7, 32'd256, 32'd0, 8, 1'b1, 1'b0);
        do_clear();
        run("R7", 4'd7, 32'd1, 32'd0, 0, 1'b1, 1'b0);
        do_clear();
        // R8
        run("R8", 4'd8, 32'h0005_7FFF, 32'd0, 7, 1'b1, 1'b0);
        do_clear();
        run("R8", 4'd8, 32'h8000_0003, 32'd0, 7, 1'b1, 1'b0);
        do_clear();
        run("R8", 4'd9, 32'hFFF0_0020, 32'd0, 4, 1'b1, 1'b0);
        do_clear();
        run("R8", 4'd9, 32'h7FFF_0010, 32'd0, 16, 1'b1, 1'b0);

        // random mix
        for (int i = 0; i < 1500; i++) begin
            logic [3:0] ro;
            logic [31:0] ra, rb;
            ro = 4'($urandom_range(0, 11));
            ra = $urandom();
            rb = $urandom();
            if ($urandom_range(0, 3) == 0) ra = {ra[31], {3{ra[31]}}, ra[27:0]} ^ 32'h4000_0000;
            run("R2..R8 random", ro, ra, rb, $urandom_range(0, 31),
                $urandom_range(0, 7) != 0, $urandom_range(0, 5) == 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule